// File: doc/BRIEF.md
# Hardware Task Context Switch Unit

This unit keeps the architectural state of up to 32 hardware tasks for a 32-bit stack-machine core and presents the state of exactly one of them, the live task, to the core. The live state is a program counter, a data-stack pointer, a return-stack pointer and a status word. The core updates them through a write port while it runs. All other tasks keep their state in an on-chip register file, one entry per task ID.

A switch starts when the core issues a yield or when the time-slice counter runs out. The unit picks the next enabled task in round-robin order after the live one. It then spends two cycles with `switch_hold` high, which stalls the core. In the first cycle the outgoing context is written to storage. In the second cycle the incoming context is read and loaded into the live registers. Software sets or clears a task's enable bit through a small write port. Enabling a task also seeds its start address.

The controller is a three-state machine. In `ST_RUN` the core executes. `ST_RUN` goes to `ST_SAVE` when a trigger finds another enabled task. `ST_SAVE` always goes to `ST_LOAD`. `ST_LOAD` always returns to `ST_RUN`. A trigger that finds no other enabled task leaves the machine in `ST_RUN`.

Top module: `ctxsw_unit`

## Requirements
- R1: Up to NUM_TASKS (default 32) contexts are kept, each made of PC, data-stack pointer, return-stack pointer and status word. A task that is switched out and later switched back in resumes with exactly the values it had when it left, and `live_id` changes only when a switch completes.
- R2: While `switch_hold` is low, `upd_en` high loads `upd_pc`, `upd_dsp`, `upd_rsp` and `upd_stat` into the live registers at the next rising edge.
- R3: Suppose a trigger is accepted in cycle T. Then `switch_hold` is high in cycles T+1 and T+2 only, and from cycle T+3 the live outputs show the incoming task.
- R4: A switch is atomic. While `switch_hold` is high, `upd_en`, `yield_req` and timer expiry have no effect, and the live outputs keep the outgoing task's values.
- R5: `yield_req` high in a running cycle triggers a switch. The target is the first enabled task ID after the live one in ascending order, wrapping modulo NUM_TASKS, and the choice uses the enable mask as it stood before that cycle's enable write.
- R6: If a trigger finds no enabled task other than the live one, no switch happens: `switch_hold` stays low, the live task continues, and the slice counter restarts.
- R7: With `slice_len` = L and L not 0, the elapsed counter restarts at 0 on every trigger. It advances once per running cycle and triggers a preemption in the running cycle where it equals L-1 or more. Setting `slice_len` = 0 disables preemption. The counter does not advance during a switch.
- R8: After reset, task 0 is live with PC, both stack pointers and status equal to 0, `task_mask` is 1 (only bit 0 set), all stored contexts are 0, and `switch_hold` is low.
- R9: While `switch_hold` is low, `en_wr` writes `en_val` into bit `en_id` of `task_mask`. If `en_val` is 1 and `en_id` is not the live task, the stored context of that task is also set to PC = `en_pc`, with pointers and status 0. A write to the live task's ID changes only its mask bit. `en_wr` is ignored while `switch_hold` is high.
- R10: A live task whose enable bit is cleared keeps running until the next trigger, and then it is switched away like any other task.
- R11: A yield and a timer expiry in the same running cycle produce one switch, not two, and the counter restarts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Core writes live registers |
| upd_pc | input | PC_W | New live program counter |
| upd_dsp | input | SP_W | New live data-stack pointer |
| upd_rsp | input | SP_W | New live return-stack pointer |
| upd_stat | input | STAT_W | New live status word |
| yield_req | input | 1 | Cooperative yield from the core |
| slice_len | input | CNT_W | Time-slice length in running cycles, 0 disables |
| en_wr | input | 1 | Task enable write strobe |
| en_id | input | ID_W | Task addressed by the enable write |
| en_val | input | 1 | New enable bit value |
| en_pc | input | PC_W | Start PC seeded when enabling a non-live task |
| live_id | output | ID_W | ID of the live task |
| live_pc | output | PC_W | Live program counter |
| live_dsp | output | SP_W | Live data-stack pointer |
| live_rsp | output | SP_W | Live return-stack pointer |
| live_stat | output | STAT_W | Live status word |
| switch_hold | output | 1 | High during the two switch cycles, stalls the core |
| task_mask | output | NUM_TASKS | Current task enable mask |

## Verification
The cooperative yield and the preemption timer can both raise a trigger in the same running cycle. The bench provokes this directly: after a switch it waits exactly `slice_len`-1 idle cycles and then raises `yield_req` in the cycle where the counter expires. The same overlap also happens by chance during the random phase. A cycle-level bench model judges the outcome. The correct result is a single two-cycle hold, one change of `live_id`, and a counter that starts again from zero, so the next preemption arrives `slice_len` running cycles later and not sooner.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    // Controller states of the switch sequencer
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SAVE = 2'd1,
        ST_LOAD = 2'd2
    } sw_state_e;

endpackage

// File: rtl/ctxsw_rr_pick.sv
// Round-robin selector: first set mask bit after cur_id, wrapping, excluding cur_id.
module ctxsw_rr_pick #(
    parameter int NUM_TASKS = 32,
    parameter int ID_W      = $clog2(NUM_TASKS)
) (
    input  logic [NUM_TASKS-1:0] mask,
    input  logic [ID_W-1:0]      cur_id,
    output logic                 found,
    output logic [ID_W-1:0]      pick
);

    localparam logic [ID_W:0] N_L = (ID_W+1)'(NUM_TASKS);

    logic [ID_W:0] slot;

    always_comb begin
        found = 1'b0;
        pick  = cur_id;
        slot  = '0;
        // Walk from the farthest candidate to the nearest so the nearest wins.
        for (int k = NUM_TASKS - 1; k >= 1; k--) begin
            slot = {1'b0, cur_id} + (ID_W+1)'(k);
            if (slot >= N_L) begin
                slot = slot - N_L;
            end
            if (mask[slot[ID_W-1:0]]) begin
                found = 1'b1;
                pick  = slot[ID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ctxsw_ctx_store.sv
// Per-task context register file: one write port, one combinational read port.
module ctxsw_ctx_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 68,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ctxsw_slice_timer.sv
// Elapsed-run counter for preemption.
module ctxsw_slice_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             restart,
    input  logic [CNT_W-1:0] slice_len,
    output logic             expired
);

    logic [CNT_W-1:0] elapsed_q;
    logic [CNT_W:0]   elapsed_p1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (restart) begin
            elapsed_q <= '0;
        end else if (count_en) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    always_comb begin
        elapsed_p1 = {1'b0, elapsed_q} + 1'b1;
        expired    = (slice_len != '0) && (elapsed_p1 >= {1'b0, slice_len});
    end

endmodule

// File: rtl/ctxsw_unit.sv
module ctxsw_unit
    import ctxsw_pkg::*;
#(
    parameter int NUM_TASKS = 32,
    parameter int PC_W      = 32,
    parameter int SP_W      = 10,
    parameter int STAT_W    = 16,
    parameter int CNT_W     = 16,
    parameter int ID_W      = $clog2(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en,
    input  logic [PC_W-1:0]      upd_pc,
    input  logic [SP_W-1:0]      upd_dsp,
    input  logic [SP_W-1:0]      upd_rsp,
    input  logic [STAT_W-1:0]    upd_stat,
    input  logic                 yield_req,
    input  logic [CNT_W-1:0]     slice_len,
    input  logic                 en_wr,
    input  logic [ID_W-1:0]      en_id,
    input  logic                 en_val,
    input  logic [PC_W-1:0]      en_pc,
    output logic [ID_W-1:0]      live_id,
    output logic [PC_W-1:0]      live_pc,
    output logic [SP_W-1:0]      live_dsp,
    output logic [SP_W-1:0]      live_rsp,
    output logic [STAT_W-1:0]    live_stat,
    output logic                 switch_hold,
    output logic [NUM_TASKS-1:0] task_mask
);

    localparam int CTX_W = PC_W + 2 * SP_W + STAT_W;

    sw_state_e state_q, state_d;

    logic [ID_W-1:0]      cur_q, nxt_q;
    logic [PC_W-1:0]      pc_q;
    logic [SP_W-1:0]      dsp_q, rsp_q;
    logic [STAT_W-1:0]    stat_q;
    logic [NUM_TASKS-1:0] mask_q;

    logic             running, trig, expired, found;
    logic [ID_W-1:0]  pick;
    logic             seed_we, st_we;
    logic [ID_W-1:0]  st_waddr;
    logic [CTX_W-1:0] st_wdata, st_rdata, live_ctx;

    assign running = (state_q == ST_RUN);
    assign trig    = running && (yield_req || expired);
    assign seed_we = running && en_wr && en_val && (en_id != cur_q);
    assign live_ctx = {pc_q, dsp_q, rsp_q, stat_q};

    ctxsw_rr_pick #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W)) u_pick (
        .mask   (mask_q),
        .cur_id (cur_q),
        .found  (found),
        .pick   (pick)
    );

    ctxsw_slice_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (running),
        .restart   (trig),
        .slice_len (slice_len),
        .expired   (expired)
    );

    // Store write port: save of the outgoing task, or seeding on enable.
    always_comb begin
        st_we    = (state_q == ST_SAVE) || seed_we;
        st_waddr = (state_q == ST_SAVE) ? cur_q : en_id;
        st_wdata = (state_q == ST_SAVE) ? live_ctx
                                        : {en_pc, {(2*SP_W+STAT_W){1'b0}}};
    end

    ctxsw_ctx_store #(.DEPTH(NUM_TASKS), .DW(CTX_W), .AW(ID_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (nxt_q),
        .rdata (st_rdata)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (trig && found) state_d = ST_SAVE;
            ST_SAVE: state_d = ST_LOAD;
            ST_LOAD: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Live context, task ID, target latch and enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            nxt_q  <= '0;
            pc_q   <= '0;
            dsp_q  <= '0;
            rsp_q  <= '0;
            stat_q <= '0;
            mask_q <= NUM_TASKS'(1);
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (upd_en) begin
                        pc_q   <= upd_pc;
                        dsp_q  <= upd_dsp;
                        rsp_q  <= upd_rsp;
                        stat_q <= upd_stat;
                    end
                    if (en_wr) begin
                        mask_q[en_id] <= en_val;
                    end
                    if (trig && found) begin
                        nxt_q <= pick;
                    end
                end
                ST_SAVE: begin
                end
                ST_LOAD: begin
                    {pc_q, dsp_q, rsp_q, stat_q} <= st_rdata;
                    cur_q <= nxt_q;
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        switch_hold = (state_q != ST_RUN);
        live_id     = cur_q;
        live_pc     = pc_q;
        live_dsp    = dsp_q;
        live_rsp    = rsp_q;
        live_stat   = stat_q;
        task_mask   = mask_q;
    end

endmodule

// File: rtl/ctxsw_unit_chk.sv
module ctxsw_unit_chk #(
    parameter int NUM_TASKS = 32,
    parameter int PC_W      = 32,
    parameter int SP_W      = 10,
    parameter int STAT_W    = 16,
    parameter int ID_W      = $clog2(NUM_TASKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ID_W-1:0]      live_id,
    input logic [PC_W-1:0]      live_pc,
    input logic [SP_W-1:0]      live_dsp,
    input logic [SP_W-1:0]      live_rsp,
    input logic [STAT_W-1:0]    live_stat,
    input logic                 switch_hold,
    input logic [NUM_TASKS-1:0] task_mask
);

    // R3: hold lasts exactly two cycles
    a_r3_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switch_hold) |=> switch_hold ##1 !switch_hold);

    // R4: live outputs frozen through the switch
    a_r4_live_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switch_hold) |=> ($stable(live_pc) && $stable(live_dsp) &&
                                $stable(live_rsp) && $stable(live_stat) &&
                                $stable(live_id)));

    // R5: a completed switch lands on a different task
    a_r5_switch_moves: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(switch_hold) |-> (live_id != $past(live_id)));

    // R1: live task ID only changes as a switch completes
    a_r1_id_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_hold && !$past(switch_hold)) |-> $stable(live_id));

    // R9: enable writes ignored during a switch
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        switch_hold |=> $stable(task_mask));

endmodule

bind ctxsw_unit ctxsw_unit_chk #(
    .NUM_TASKS (NUM_TASKS),
    .PC_W      (PC_W),
    .SP_W      (SP_W),
    .STAT_W    (STAT_W),
    .ID_W      (ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .live_id     (live_id),
    .live_pc     (live_pc),
    .live_dsp    (live_dsp),
    .live_rsp    (live_rsp),
    .live_stat   (live_stat),
    .switch_hold (switch_hold),
    .task_mask   (task_mask)
);

// File: tb/sim_ctxsw_unit.sv
module sim_ctxsw_unit;

    localparam int NT = 32;
    localparam int IW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [9:0]  upd_dsp = '0, upd_rsp = '0;
    logic [15:0] upd_stat = '0;
    logic        yield_req = 1'b0;
    logic [15:0] slice_len = '0;
    logic        en_wr = 1'b0;
    logic [IW-1:0] en_id = '0;
    logic        en_val = 1'b0;
    logic [31:0] en_pc = '0;
    logic [IW-1:0] live_id;
    logic [31:0] live_pc;
    logic [9:0]  live_dsp, live_rsp;
    logic [15:0] live_stat;
    logic        switch_hold;
    logic [NT-1:0] task_mask;

    ctxsw_unit u0 (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_dsp(upd_dsp), .upd_rsp(upd_rsp), .upd_stat(upd_stat),
        .yield_req(yield_req), .slice_len(slice_len), .en_wr(en_wr),
        .en_id(en_id), .en_val(en_val), .en_pc(en_pc), .live_id(live_id),
        .live_pc(live_pc), .live_dsp(live_dsp), .live_rsp(live_rsp),
        .live_stat(live_stat), .switch_hold(switch_hold), .task_mask(task_mask)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R8";

    // Bench model of the requirements
    logic [31:0] m_spc [NT];
    logic [9:0]  m_sdsp [NT], m_srsp [NT];
    logic [15:0] m_sstat [NT];
    logic [31:0] m_pc;
    logic [9:0]  m_dsp, m_rsp;
    logic [15:0] m_stat;
    logic [NT-1:0] m_mask;
    int m_cur, m_nxt, m_st, m_cnt;   // m_st: 0 run, 1 save, 2 load

    function automatic int rr_next(input logic [NT-1:0] msk, input int cur);
        for (int k = 1; k < NT; k++) begin
            if (msk[(cur + k) % NT]) return (cur + k) % NT;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NT; i++) begin
            m_spc[i] = '0; m_sdsp[i] = '0; m_srsp[i] = '0; m_sstat[i] = '0;
        end
        m_pc = '0; m_dsp = '0; m_rsp = '0; m_stat = '0;
        m_mask = 1; m_cur = 0; m_nxt = 0; m_st = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        if (m_st == 0) begin
            int  tgt;
            bit  exp_t, trg;
            exp_t = (slice_len != 0) && (m_cnt + 1 >= int'(slice_len));
            trg   = yield_req || exp_t;          // R11: one trigger either way
            tgt   = rr_next(m_mask, m_cur);
            if (upd_en) begin
                m_pc = upd_pc; m_dsp = upd_dsp; m_rsp = upd_rsp; m_stat = upd_stat;
            end
            if (en_wr) begin
                if (en_val && int'(en_id) != m_cur) begin
                    m_spc[en_id] = en_pc; m_sdsp[en_id] = '0;
                    m_srsp[en_id] = '0;  m_sstat[en_id] = '0;
                end
                m_mask[en_id] = en_val;
            end
            if (trg) begin
                m_cnt = 0;
                if (tgt >= 0) begin m_st = 1; m_nxt = tgt; end
            end else begin
                m_cnt = (m_cnt + 1) & 16'hFFFF;
            end
        end else if (m_st == 1) begin
            m_spc[m_cur] = m_pc; m_sdsp[m_cur] = m_dsp;
            m_srsp[m_cur] = m_rsp; m_sstat[m_cur] = m_stat;
            m_st = 2;
        end else begin
            m_pc = m_spc[m_nxt]; m_dsp = m_sdsp[m_nxt];
            m_rsp = m_srsp[m_nxt]; m_stat = m_sstat[m_nxt];
            m_cur = m_nxt; m_st = 0;
        end
    endtask

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("switch_hold", 64'(switch_hold), 64'(m_st != 0));
        chk("live_id",     64'(live_id),     64'(m_cur));
        chk("live_pc",     64'(live_pc),     64'(m_pc));
        chk("live_dsp",    64'(live_dsp),    64'(m_dsp));
        chk("live_rsp",    64'(live_rsp),    64'(m_rsp));
        chk("live_stat",   64'(live_stat),   64'(m_stat));
        chk("task_mask",   64'(task_mask),   64'(m_mask));
    endtask

    task automatic idle_inputs();
        upd_en = 0; yield_req = 0; en_wr = 0; en_val = 0;
    endtask

    // One clock: model follows the driven inputs, then outputs are compared.
    task automatic step();
        model_step();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic enable(input int id, input bit v, input logic [31:0] pc);
        en_wr = 1; en_id = IW'(id); en_val = v; en_pc = pc;
        step();
    endtask

    task automatic upd(input logic [31:0] pc, input logic [9:0] d, input logic [9:0] r, input logic [15:0] s);
        upd_en = 1; upd_pc = pc; upd_dsp = d; upd_rsp = r; upd_stat = s;
        step();
    endtask

    task automatic yield_now();
        yield_req = 1;
        step();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset state
        tag = "R8"; compare_all();

        // R6: yield with only task 0 enabled stays put
        tag = "R6";
        upd(32'h10, 10'd3, 10'd4, 16'h1);
        yield_now();
        step(); step();
        chk("R6 no hold", 64'(switch_hold), 64'(0));

        // R9: seed tasks 5 and 9; write to live id changes only the mask
        tag = "R9";
        enable(5, 1, 32'h100);
        enable(9, 1, 32'h200);
        enable(0, 1, 32'h55);
        chk("R9 live pc untouched", 64'(live_pc), 64'(32'h10));

        // R5/R3: yield walks 0 -> 5 -> 9 -> 0
        tag = "R5";
        yield_now();
        chk("R3 hold cycle1", 64'(switch_hold), 64'(1));
        step();
        chk("R3 hold cycle2", 64'(switch_hold), 64'(1));
        step();
        chk("R5 target 5", 64'(live_id), 64'(5));
        chk("R9 seeded pc", 64'(live_pc), 64'(32'h100));
        upd(32'h111, 10'd7, 10'd8, 16'hAA);
        yield_now(); step(); step();
        chk("R5 target 9", 64'(live_id), 64'(9));
        yield_now(); step(); step();
        // R1: task 0 resumes with its saved context
        tag = "R1";
        chk("R1 back to 0", 64'(live_id), 64'(0));
        chk("R1 restored pc", 64'(live_pc), 64'(32'h10));

        // R4: core writes, yields and enables during hold are ignored
        tag = "R4";
        yield_now();
        upd_en = 1; upd_pc = 32'hDEAD; yield_req = 1; en_wr = 1; en_id = 5; en_val = 0;
        step();
        upd_en = 1; upd_pc = 32'hBEEF; yield_req = 1;
        step();
        chk("R4 landed on 5", 64'(live_id), 64'(5));
        chk("R4 pc kept", 64'(live_pc), 64'(32'h111));
        step(); step();

        // R7: preemption with a 5-cycle slice
        tag = "R7";
        slice_len = 16'd5;
        repeat (30) step();

        // R11: yield exactly on expiry gives one switch
        tag = "R11";
        while (switch_hold || m_st != 0) step();
        step(); step(); step(); step();
        repeat (3) begin
            if (m_st == 0) yield_now(); else step();
        end
        repeat (12) step();

        // R10: disable the live task, it runs until the next trigger
        tag = "R10";
        slice_len = 16'd0;
        while (m_st != 0) step();
        enable(int'(live_id), 0, 32'h0);
        step(); step();
        yield_now(); step(); step();
        chk("R10 left disabled task", 64'(task_mask[live_id]), 64'(1));

        // R2 plus everything: constrained random traffic
        tag = "R2";
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 200 == 0) begin
                case ($urandom % 4)
                    0: slice_len = 0;
                    1: slice_len = 3;
                    2: slice_len = 7;
                    default: slice_len = 20;
                endcase
            end
            upd_en = ($urandom % 2) == 0;
            upd_pc = $urandom; upd_dsp = 10'($urandom); upd_rsp = 10'($urandom);
            upd_stat = 16'($urandom);
            yield_req = ($urandom % 8) == 0;
            en_wr = ($urandom % 10) == 0;
            en_id = IW'($urandom);
            en_val = ($urandom % 10) < 7;
            en_pc = $urandom;
            step();
        end
        finish_run();
    end

endmodule